// File: doc/BRIEF.md
# E3 far-end block error monitor

This block handles the remote-error indicator bit (the A bit) of a G.751 E3 link, in both the receive and the transmit direction. An upstream framer sends one single-cycle strobe per received frame. With the strobe it gives the A bit captured from that frame and a flag that is high when the frame's BIP-4 nibble was in error. Frame alignment, BIP-4 computation and serialization all happen outside this block.

On receive, the block counts frames that report a far-end error. It does this only when far-end checking is enabled. The count goes into a 16-bit saturating counter that the host reads as two byte registers. On transmit, the block supplies the A bit for each outbound frame. A local BIP-4 error is reflected back to the far end in the next frame that starts after the error.

A small register port holds the configuration byte and the two counter bytes. Reading the high byte captures the low byte, so the two bytes always come from the same counter value. The same read also clears the counter.

Top module: `e3_febe_mon`

## Requirements
- R1: After reset, the configuration byte reads 0, both counter bytes read 0 and `tx_a_bit` is 0.
- R2: Address 0 is the configuration byte. Bit 0 enables far-end error checking and bit 1 enables transmit A-bit insertion. Both bits are read/write, and bits 7:2 always read 0.
- R3: While bit 0 is set, each `rx_frame_stb` pulse with `rx_a_bit`=1 adds exactly one to the counter.
- R4: The counter does not change for a frame whose A bit is 0, for cycles without `rx_frame_stb`, or for any frame while bit 0 is clear.
- R5: The counter saturates at 0xFFFF and does not wrap.
- R6: A read of address 1 returns counter bits 15:8, captures bits 7:0 into a snapshot that address 2 returns, and clears the counter. If a counted frame arrives in the same cycle as the read, the counter becomes 1.
- R7: Writes to addresses 1 and 2 have no effect. The counter and the snapshot are read-only.
- R8: With bit 1 set, a frame flagged with `rx_bip_err` makes `tx_a_bit` 1 for the next outbound frame. `tx_a_bit` takes the new frame's value in the cycle after `tx_frame_stb` and holds it until the next strobe.
- R9: Several errors that arrive before one `tx_frame_stb` produce a single frame with the A bit set to 1. The frame after that carries 0 unless a new error arrived in between.
- R10: An error that arrives in the same cycle as `tx_frame_stb` sets the A bit of the following frame, not of the frame starting in that cycle.
- R11: While bit 1 is clear, `tx_a_bit` is 0, and errors received during that time are not remembered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_frame_stb | input | 1 | One-cycle pulse per received frame |
| rx_a_bit | input | 1 | A bit of the received frame |
| rx_bip_err | input | 1 | BIP-4 nibble of the received frame was in error |
| tx_frame_stb | input | 1 | One-cycle pulse at each outbound frame start |
| tx_a_bit | output | 1 | A bit value for the current outbound frame |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational, 0 when not reading |

## Verification
A counter that misses an increment, or that wraps, shows up at the next high-byte and snapshot read pair. A faulty clear-on-read or a faulty snapshot capture shows up on the very next read. A pending-error flag that fails to collapse, fails to clear, or takes effect one frame early becomes visible one cycle after the affected `tx_frame_stb`. Because the reference model is compared with both outputs on every clock, any such fault is reported in the first cycle in which it reaches a port.

// File: rtl/e3_febe_mon.sv
module e3_febe_mon (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_frame_stb,
  input  logic       rx_a_bit,
  input  logic       rx_bip_err,
  input  logic       tx_frame_stb,
  output logic       tx_a_bit,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata
);
  localparam logic [15:0] CNT_MAX = 16'hFFFF;

  logic        chk_en, ins_en;
  logic [15:0] fe_cnt;
  logic [7:0]  lsb_snap;
  logic        err_pend, a_cur;

  wire rd_msb  = reg_rd && (reg_addr == 2'd1);
  wire fe_hit  = rx_frame_stb && rx_a_bit && chk_en;
  wire bip_hit = rx_frame_stb && rx_bip_err && ins_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_en <= 1'b0;
      ins_en <= 1'b0;
    end else if (reg_wr && reg_addr == 2'd0) begin
      chk_en <= reg_wdata[0];
      ins_en <= reg_wdata[1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fe_cnt   <= '0;
      lsb_snap <= '0;
    end else if (rd_msb) begin
      lsb_snap <= fe_cnt[7:0];
      fe_cnt   <= {15'd0, fe_hit};
    end else if (fe_hit && fe_cnt != CNT_MAX) begin
      fe_cnt <= fe_cnt + 16'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_pend <= 1'b0;
      a_cur    <= 1'b0;
    end else if (tx_frame_stb) begin
      a_cur    <= err_pend && ins_en;
      err_pend <= bip_hit;
    end else begin
      err_pend <= err_pend || bip_hit;
    end
  end

  assign tx_a_bit = a_cur && ins_en;

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (reg_addr)
        2'd0:    reg_rdata = {6'd0, ins_en, chk_en};
        2'd1:    reg_rdata = fe_cnt[15:8];
        2'd2:    reg_rdata = lsb_snap;
        default: reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/e3_febe_mon_chk.sv
module e3_febe_mon_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_frame_stb,
  input logic        rx_a_bit,
  input logic        tx_frame_stb,
  input logic        tx_a_bit,
  input logic        reg_rd,
  input logic [1:0]  reg_addr,
  input logic [7:0]  reg_rdata,
  input logic [15:0] cnt,
  input logic        en_chk,
  input logic        en_ins
);
  wire rd1 = reg_rd && reg_addr == 2'd1;
  wire hit = rx_frame_stb && rx_a_bit && en_chk;

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !rd1 && cnt != 16'hFFFF) |=> cnt == $past(cnt) + 16'd1);
  // R4
  no_idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !rd1) |=> $stable(cnt));
  // R5
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 16'hFFFF && !rd1) |=> cnt == 16'hFFFF);
  // R6
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd1 |=> cnt <= 16'd1);
  // R2
  cfg_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 2'd0) |-> reg_rdata[7:2] == 6'd0);
  // R8
  a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_frame_stb && en_ins) |=> ($stable(tx_a_bit) || !en_ins));
  // R11
  tx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_ins |-> !tx_a_bit);
endmodule

bind e3_febe_mon e3_febe_mon_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_frame_stb(rx_frame_stb), .rx_a_bit(rx_a_bit),
  .tx_frame_stb(tx_frame_stb), .tx_a_bit(tx_a_bit), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata), .cnt(fe_cnt),
  .en_chk(chk_en), .en_ins(ins_en)
);

// File: tb/tb_e3_febe_mon.sv
module tb_e3_febe_mon;
  logic clk = 0, rst_n = 0;
  logic rx_frame_stb = 0, rx_a_bit = 0, rx_bip_err = 0, tx_frame_stb = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic tx_a_bit;
  logic [7:0] reg_rdata;

  int checks = 0, errors = 0;
  int m_cfg = 0, m_cnt = 0, m_snap = 0, m_pend = 0, m_a = 0;
  bit done = 0;

  always #5 clk = ~clk;

  e3_febe_mon dut (.*);

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(bit rs, bit a, bit be, bit ts, bit wr, bit rd,
                     int addr, int wd, int dexp, string dtag);
    int e_rd, set, hit;
    rx_frame_stb = rs; rx_a_bit = a; rx_bip_err = be; tx_frame_stb = ts;
    reg_wr = wr; reg_rd = rd; reg_addr = addr[1:0]; reg_wdata = wd[7:0];
    #1;
    e_rd = !rd ? 0 : addr == 0 ? m_cfg : addr == 1 ? (m_cnt >> 8) : addr == 2 ? m_snap : 0;
    check(addr == 0 ? "R2 rdata" : "R6 rdata", int'(reg_rdata), e_rd);
    check("R8 tx_a_bit", int'(tx_a_bit), m_a & (m_cfg >> 1) & 1);
    if (dexp >= 0) check(dtag, int'(reg_rdata), dexp);
    @(posedge clk);
    hit = rs && a && (m_cfg & 1);
    set = rs && be && ((m_cfg >> 1) & 1);
    if (rd && addr == 1) begin
      m_snap = m_cnt & 255;
      m_cnt = hit ? 1 : 0;
    end else if (hit && m_cnt < 65535) m_cnt++;
    if (ts) begin
      m_a = m_pend & (m_cfg >> 1) & 1;
      m_pend = set;
    end else m_pend = m_pend | set;
    if (wr && addr == 0) m_cfg = wd & 3;
    @(negedge clk);
  endtask

  task automatic idle(); cyc(0,0,0,0,0,0,0,0,-1,""); endtask
  task automatic frm(bit a, bit be, bit ts); cyc(1,a,be,ts,0,0,0,0,-1,""); endtask
  task automatic wcfg(int addr, int v); cyc(0,0,0,0,1,0,addr,v,-1,""); endtask
  task automatic rd(int addr, int exp, string tag); cyc(0,0,0,0,0,1,addr,0,exp,tag); endtask
  task automatic txs(); cyc(0,0,0,1,0,0,0,0,-1,""); endtask
  task automatic txa(int exp, string tag); check(tag, int'(tx_a_bit), exp); endtask

  initial begin
    #1500000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    txa(0, "R1 tx_a_bit");
    rd(0, 0, "R1 cfg"); rd(1, 0, "R1 msb"); rd(2, 0, "R1 lsb");
    // R2 config read/write, upper bits zero
    wcfg(0, 255); rd(0, 3, "R2 cfg 0xFF");
    wcfg(0, 2); rd(0, 2, "R2 cfg 2");
    // R4 counting disabled
    for (int i = 0; i < 3; i++) frm(1, 0, 0);
    wcfg(0, 3);
    rd(1, 0, "R4 msb disabled"); rd(2, 0, "R4 lsb disabled");
    // R3 / R4 counting mix
    for (int i = 0; i < 5; i++) begin frm(1, 0, 0); frm(0, 0, 0); cyc(0,1,0,0,0,0,0,0,-1,""); end
    rd(1, 0, "R3 msb"); rd(2, 5, "R3 lsb count 5");
    rd(1, 0, "R6 msb cleared"); rd(2, 0, "R6 lsb cleared");
    // R7 read-only
    for (int i = 0; i < 3; i++) frm(1, 0, 0);
    rd(1, 0, "R7 msb");
    wcfg(2, 8'h55); wcfg(1, 8'hAA);
    rd(2, 3, "R7 snapshot kept"); rd(1, 0, "R7 counter not written");
    // R6 same-cycle event with clearing read
    frm(1, 0, 0); frm(1, 0, 0);
    cyc(1,1,0,0,0,1,1,0,0,"R6 msb same cycle");
    rd(1, 0, "R6 msb"); rd(2, 1, "R6 lsb keeps event");
    // R6 two-byte snapshot
    for (int i = 0; i < 300; i++) frm(1, 0, 0);
    rd(1, 1, "R6 msb 300"); rd(2, 44, "R6 lsb 300");
    // R5 saturation
    for (int i = 0; i < 65540; i++) frm(1, 0, 0);
    rd(1, 255, "R5 msb sat"); rd(2, 255, "R5 lsb sat");
    // R8 error echoed in next frame
    txs(); txa(0, "R8 no error");
    frm(0, 1, 0); idle(); txa(0, "R8 not yet");
    txs(); txa(1, "R8 echoed");
    idle(); idle(); txa(1, "R8 held");
    // R9 cleared after emission, collapse of several errors
    txs(); txa(0, "R9 cleared");
    frm(0, 1, 0); frm(0, 1, 0); frm(0, 1, 0);
    txs(); txa(1, "R9 collapsed");
    txs(); txa(0, "R9 single frame");
    // R10 same-cycle error and frame start
    frm(0, 1, 1); txa(0, "R10 not current frame");
    txs(); txa(1, "R10 following frame");
    txs(); txa(0, "R10 cleared");
    // R11 insertion disabled
    frm(0, 1, 0); txs(); txs(); wcfg(0, 1);
    txa(0, "R11 disabled output");
    frm(0, 1, 0); txs(); txa(0, "R11 disabled frame");
    wcfg(0, 3); txs(); txa(0, "R11 not remembered");
    idle();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule